// File: doc/BRIEF.md
# Global Bypass Abort Control Register

This block holds the global bypass attribute register of an address-translation unit. While translation is globally disabled, it decides whether incoming transactions are passed through untranslated or terminated with an abort. While translation is enabled, it sends every transaction to the normal translation path.

Software reaches the register through a 32-bit register port at a fixed byte offset. A new setting is only accepted when the write carries the update flag. The block then completes the change in a short fixed pipeline. The update flag reads as busy until the new setting governs traffic, so software polls it to learn when the change has taken effect.

On the transaction side, each request gets a verdict in the same cycle it is presented.

Top module: `bypass_gate_ctrl`

## Requirements
- R1: After reset, a read at offset 0x44 returns 0, and with translation disabled every transaction gets the bypass verdict.
- R2: The register is 32 bits wide at byte offset 0x44. A read there returns the committed value in bits 30..0 and the busy flag in bit 31. Bits other than 31 are stored as written.
- R3: With `xlat_en` low, the verdict is abort (2'b01) when committed bit 20 is 1, and bypass (2'b00) when it is 0. `verdict_valid` follows `txn_valid` in the same cycle.
- R4: With `xlat_en` high, the verdict is translate (2'b10) whatever the register holds.
- R5: A write at offset 0x44 with bit 31 clear is ignored. The committed value and all verdicts stay unchanged.
- R6: A write at offset 0x44 with bit 31 set, made while idle, is accepted. Bit 31 then reads 1 for exactly the two cycles after the accepting clock edge, and 0 afterwards. Bit 31 is never kept as a stored field.
- R7: The newly written value appears in reads, and the verdicts switch, in the same cycle that bit 31 drops to 0. Every transaction from that cycle on uses the new setting.
- R8: While an update is pending, every write at offset 0x44 is ignored, even one with bit 31 set.
- R9: Reads at any other offset return 0. Writes at any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| xlat_en | input | 1 | Global translation enable |
| txn_valid | input | 1 | A transaction asks for a verdict this cycle |
| verdict_valid | output | 1 | The verdict belongs to a transaction |
| verdict | output | 2 | 00 bypass, 01 abort, 10 translate |

## Verification
The bench targets the exact cycle in which bit 31 falls. A design with an off-by-one pipeline would let a transaction through with the stale setting, or report completion before the new verdict applies. Other cases are:
- writes lacking the update flag, which a careless design would commit;
- writes arriving during the busy window, which a careless design would use to restart or overwrite the pending value;
- the translation enable overriding a set abort bit;
- a write whose upper bit set leaks into later reads as a sticky flag;
- writes at a neighbouring offset that alias into the register.

// File: rtl/bypass_gate_ctrl.sv
module bypass_gate_ctrl #(
  parameter int              ADDR_W     = 12,
  parameter logic [11:0]     REG_OFFSET = 12'h044,
  parameter int              UPD_LAT    = 2,
  parameter int              ABORT_BIT  = 20,
  parameter int              UPD_BIT    = 31,
  parameter logic [31:0]     RST_VAL    = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xlat_en,
  input  logic              txn_valid,
  output logic              verdict_valid,
  output logic [1:0]        verdict
);

  localparam int          CNT_W    = $clog2(UPD_LAT + 1);
  localparam logic [31:0] UPD_MASK = 32'(1) << UPD_BIT;
  localparam logic [1:0]  V_BYPASS = 2'b00;
  localparam logic [1:0]  V_ABORT  = 2'b01;
  localparam logic [1:0]  V_XLATE  = 2'b10;

  logic [31:0]      live_q;
  logic [31:0]      stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             busy;
  logic             accept;

  assign hit    = (reg_addr == REG_OFFSET[ADDR_W-1:0]);
  assign busy   = (cnt_q != '0);
  assign accept = reg_wr && hit && reg_wdata[UPD_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= RST_VAL & ~UPD_MASK;
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (accept) begin
      stage_q <= reg_wdata & ~UPD_MASK;
      cnt_q   <= CNT_W'(UPD_LAT);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) live_q <= stage_q;
    end
  end

  assign reg_rdata     = hit ? ((live_q & ~UPD_MASK) | (busy ? UPD_MASK : 32'h0)) : 32'h0;
  assign verdict_valid = txn_valid;
  assign verdict       = xlat_en ? V_XLATE : (live_q[ABORT_BIT] ? V_ABORT : V_BYPASS);

endmodule

// File: rtl/bypass_gate_ctrl_chk.sv
module bypass_gate_ctrl_chk #(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h044,
  parameter int          UPD_LAT    = 2,
  parameter int          ABORT_BIT  = 20,
  parameter int          UPD_BIT    = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              xlat_en,
  input logic              txn_valid,
  input logic              verdict_valid,
  input logic [1:0]        verdict,
  input logic              busy,
  input logic [31:0]       live
);

  logic at_reg;
  assign at_reg = (reg_addr == REG_OFFSET[ADDR_W-1:0]);

  AST_XLAT_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_en |-> verdict == 2'b10); // R4

  AST_ABORT_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlat_en && at_reg && !reg_rdata[UPD_BIT]) |-> ((verdict == 2'b01) == reg_rdata[ABORT_BIT])); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid == txn_valid); // R3

  AST_NOUPD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && at_reg && !reg_wdata[UPD_BIT] && !busy) |=> $stable(live)); // R5

  AST_SWITCH_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live) |-> $fell(busy)); // R7

  AST_NO_STICKY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !live[UPD_BIT]); // R6

  AST_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !at_reg |-> reg_rdata == 32'h0); // R9

  if (UPD_LAT == 2) begin : g_two
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy); // R6
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy); // R8
  end

endmodule

bind bypass_gate_ctrl bypass_gate_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .UPD_LAT(UPD_LAT),
  .ABORT_BIT(ABORT_BIT), .UPD_BIT(UPD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
  .txn_valid(txn_valid), .verdict_valid(verdict_valid), .verdict(verdict),
  .busy(busy), .live(live_q)
);

// File: tb/bypass_gate_ctrl_test.sv
`timescale 1ns/1ps
module bypass_gate_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xlat_en = 1'b0;
  logic        txn_valid = 1'b0;
  logic        verdict_valid;
  logic [1:0]  verdict;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] m_live = 32'h0;
  logic [31:0] m_pend = 32'h0;
  int          m_cnt  = 0;

  always #4 clk = ~clk;

  bypass_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
    .txn_valid(txn_valid), .verdict_valid(verdict_valid), .verdict(verdict)
  );

  task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input bit xl, input bit tv, input string tag);
    logic [31:0] exp_rd;
    logic [1:0]  exp_v;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; xlat_en = xl; txn_valid = tv;
    #1;
    exp_rd = (a == 12'h044) ? ((m_live & 32'h7fff_ffff) | ((m_cnt != 0) ? 32'h8000_0000 : 32'h0)) : 32'h0;
    exp_v  = xl ? 2'b10 : (m_live[20] ? 2'b01 : 2'b00);
    check32(tag, "rdata", reg_rdata, exp_rd);
    check32(tag, "verdict", {30'h0, verdict}, {30'h0, exp_v});
    check32(tag, "verdict_valid", {31'h0, verdict_valid}, {31'h0, tv});
    @(posedge clk);
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_live = m_pend;
    end else if (wr && a == 12'h044 && d[31]) begin
      m_cnt  = 2;
      m_pend = d & 32'h7fff_ffff;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 12'h044, 0, 0, 1, "R1");
    step(0, 12'h044, 0, 0, 0, "R1");
    step(1, 12'h044, 32'h0010_0000, 0, 1, "R5");
    step(0, 12'h044, 0, 0, 1, "R5");
    step(0, 12'h044, 0, 0, 1, "R5");
    step(1, 12'h044, 32'h8010_00a5, 0, 1, "R6");
    step(0, 12'h044, 0, 0, 1, "R6");
    step(1, 12'h044, 32'h8000_0000, 0, 1, "R8");
    step(0, 12'h044, 0, 0, 1, "R7");
    step(0, 12'h044, 0, 0, 1, "R2");
    step(0, 12'h044, 0, 1, 1, "R4");
    step(0, 12'h044, 0, 0, 1, "R3");
    step(1, 12'h040, 32'h8000_0000, 0, 1, "R9");
    step(0, 12'h040, 0, 0, 1, "R9");
    step(0, 12'h048, 0, 0, 1, "R9");
    step(0, 12'h044, 0, 0, 1, "R9");
    step(1, 12'h044, 32'h8000_0000, 1, 1, "R6");
    step(0, 12'h044, 0, 0, 1, "R6");
    step(0, 12'h044, 0, 0, 1, "R6");
    step(0, 12'h044, 0, 0, 1, "R7");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [11:0] a;
      r = $urandom;
      a = (r[2:0] == 3'd0) ? 12'h040 : ((r[2:0] == 3'd1) ? 12'h048 : 12'h044);
      step(r[3], a, {r[4], 10'h0, r[5], 20'h0} | {12'h0, r[27:8]}, r[6] & r[7], r[30], "R3");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule